// File: doc/BRIEF.md
# Linked-Channel Handoff Sequencer

This block decides which of a set of linked-list DMA channels is running at any moment. Every channel alternates between data blocks and descriptor loads. A descriptor load of the first type can arm a link on the running channel and name a successor. Data-block completion events then make the handoff. Exactly one channel runs at a time. A channel that is handed away before its final data block stays pending until a later link brings it back.

Software starts a chain with a start pulse that names the head channel. After that, the block follows the stream of descriptor-load and block-done events that the surrounding engine reports for the running channel. Three cases end a step of the chain:

- A final block with no link armed ends the chain and produces a done pulse.
- A final block with a link armed hands execution to the named channel.
- A non-final block with a link armed hands execution away in the middle of the super block.

Each channel has a static fast-mode configuration bit. Only the head of a chain may have it set. Linking into a fast channel, including a fast channel linking to itself, raises a sticky configuration error and stops the chain.

Top module: `chain_link_seq`

## Requirements
- R1: After reset no channel is active or pending, `busy` is low, `cfg_err` is low and `sb_done` is low.
- R2: A start pulse while idle, with `start_id` below NUM_CH, makes that channel the only active one on the next cycle, marks it pending and clears `cfg_err`. A fast-mode head is accepted. A start pulse while busy, or with an out-of-range ID, is ignored.
- R3: Only a descriptor load with `desc_type` equal to 1 writes the running channel's link control. Bit 15 of `desc_ctrl` is the link enable and bits 4:0 are the next-channel ID. Loads of type 2 or 3 leave the link unarmed, so the next block completion causes no handoff.
- R4: A final block completion with a link armed clears the current channel's pending flag. The named channel becomes active and pending on the next cycle.
- R5: A non-final block completion with a link armed hands execution to the named channel. The current channel stays pending but is no longer active.
- R6: A self-link on a channel without fast mode keeps the same channel active. The handoff consumes the link enable, so the following block completion causes no handoff.
- R7: A final block completion with no link armed gives a one-cycle `sb_done` pulse carrying that channel's ID, drops `busy` and leaves no channel active.
- R8: A handoff into a channel whose fast-mode bit is set does not enable that channel. This includes a fast channel linking to itself. The handoff sets `cfg_err` and makes the chain idle. `cfg_err` stays set until the next accepted start.
- R9: A handoff whose next-channel ID is NUM_CH or above sets `cfg_err` and makes the chain idle.
- R10: A pending channel that a later link brings back becomes active again. Its final block completion then clears its pending flag.
- R11: At most one channel is active at a time, and an active channel is always pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_cfg | input | NUM_CH | Per-channel fast-mode configuration |
| start_valid | input | 1 | Chain start pulse |
| start_id | input | 5 | Head channel ID for the start pulse |
| desc_valid | input | 1 | Descriptor load on the running channel |
| desc_type | input | 2 | Descriptor type (1, 2 or 3) |
| desc_ctrl | input | 16 | Link control value carried by the descriptor |
| blk_done | input | 1 | Data block of the running channel completed |
| blk_final | input | 1 | The completed block ends the super block |
| act_vec | output | NUM_CH | One-hot active channel |
| pend_vec | output | NUM_CH | Channels enabled but not finished |
| busy | output | 1 | A chain is running |
| sb_done | output | 1 | One-cycle super-block done pulse |
| sb_done_id | output | $clog2(NUM_CH) | Channel that finished |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The bench builds the block with NUM_CH of 8, while the link control field keeps its full 5-bit next-channel ID. Next-channel values of 8 to 31 are therefore out of range, which brings the out-of-range handoff error within reach. The fast-mode configuration marks channels 5 and 7 as fast. This lets one chain be headed by a fast channel, a fast self-link be tried, and a link into a fast channel be tried. The bench also builds a chain that leaves a channel pending in mid super block and later returns to it.

// File: rtl/chain_link_pkg.sv
package chain_link_pkg;
  localparam int LNK_ID_W   = 5;
  localparam int LNK_CTRL_W = 16;
  localparam int LNK_EN_BIT = 15;
  localparam logic [1:0] DESC_LINKING = 2'd1;
endpackage

// File: rtl/cls_rst_sync.sv
module cls_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q    <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      meta_q    <= 1'b1;
      rst_n_out <= meta_q;
    end
  end
endmodule

// File: rtl/cls_link_bank.sv
module cls_link_bank
  import chain_link_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ID_W-1:0]            wr_ch,
  input  logic                       wr_arm,
  input  logic [LNK_ID_W-1:0]        wr_next,
  input  logic                       clr_en,
  input  logic [ID_W-1:0]            clr_ch,
  output logic [NUM_CH-1:0]          arm_vec,
  output logic [NUM_CH*LNK_ID_W-1:0] next_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic                clr_hit, wr_hit, ld;
    logic                arm_d, arm_q;
    logic [LNK_ID_W-1:0] nxt_d, nxt_q;

    assign clr_hit = clr_en && (clr_ch == ID_W'(g));
    assign wr_hit  = wr_en  && (wr_ch  == ID_W'(g));
    assign ld      = clr_hit || wr_hit;

    always_comb begin
      arm_d = arm_q;
      nxt_d = nxt_q;
      if (clr_hit) begin
        arm_d = 1'b0;
      end else if (wr_hit) begin
        arm_d = wr_arm;
        nxt_d = wr_next;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arm_q <= 1'b0;
        nxt_q <= '0;
      end else if (ld) begin
        arm_q <= arm_d;
        nxt_q <= nxt_d;
      end
    end

    assign arm_vec[g] = arm_q;
    assign next_flat[g*LNK_ID_W +: LNK_ID_W] = nxt_q;
  end
endmodule

// File: rtl/cls_link_ctrl.sv
module cls_link_ctrl
  import chain_link_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          fast_cfg,
  input  logic                       start_valid,
  input  logic [LNK_ID_W-1:0]        start_id,
  input  logic                       desc_valid,
  input  logic [1:0]                 desc_type,
  input  logic [LNK_CTRL_W-1:0]      desc_ctrl,
  input  logic                       blk_done,
  input  logic                       blk_final,
  input  logic [NUM_CH-1:0]          arm_vec,
  input  logic [NUM_CH*LNK_ID_W-1:0] next_flat,
  output logic                       wr_en,
  output logic [ID_W-1:0]            wr_ch,
  output logic                       wr_arm,
  output logic [LNK_ID_W-1:0]        wr_next,
  output logic                       clr_en,
  output logic [ID_W-1:0]            clr_ch,
  output logic                       busy,
  output logic [ID_W-1:0]            act_id,
  output logic [NUM_CH-1:0]          pend_vec,
  output logic                       sb_done,
  output logic [ID_W-1:0]            sb_done_id,
  output logic                       cfg_err
);
  logic                busy_q, busy_d;
  logic [ID_W-1:0]     act_q, act_d;
  logic [NUM_CH-1:0]   pend_q, pend_d;
  logic                err_q, err_d;
  logic                done_q, done_d;
  logic [ID_W-1:0]     did_q, did_d;
  logic                start_ok, blk_ev, handoff, tgt_ok, state_ld;
  logic                cur_arm;
  logic [LNK_ID_W-1:0] cur_next;
  logic [ID_W-1:0]     tgt;

  assign cur_arm  = arm_vec[act_q];
  assign cur_next = next_flat[act_q*LNK_ID_W +: LNK_ID_W];
  assign tgt      = cur_next[ID_W-1:0];
  assign start_ok = !busy_q && start_valid && (int'(start_id) < NUM_CH);
  assign blk_ev   = busy_q && blk_done;
  assign handoff  = blk_ev && cur_arm;
  assign tgt_ok   = (int'(cur_next) < NUM_CH) && !fast_cfg[tgt];
  assign state_ld = start_ok || blk_ev;

  always_comb begin
    busy_d = busy_q;
    act_d  = act_q;
    pend_d = pend_q;
    err_d  = err_q;
    done_d = 1'b0;
    did_d  = did_q;
    if (start_ok) begin
      busy_d                     = 1'b1;
      act_d                      = start_id[ID_W-1:0];
      pend_d[start_id[ID_W-1:0]] = 1'b1;
      err_d                      = 1'b0;
    end else if (blk_ev) begin
      if (blk_final) pend_d[act_q] = 1'b0;
      if (cur_arm) begin
        if (tgt_ok) begin
          act_d       = tgt;
          pend_d[tgt] = 1'b1;
        end else begin
          err_d  = 1'b1;
          busy_d = 1'b0;
        end
      end else if (blk_final) begin
        done_d = 1'b1;
        did_d  = act_q;
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
      did_q  <= '0;
    end else if (state_ld) begin
      busy_q <= busy_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      err_q  <= err_d;
      did_q  <= did_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign wr_en      = busy_q && desc_valid && !blk_done && (desc_type == DESC_LINKING);
  assign wr_ch      = act_q;
  assign wr_arm     = desc_ctrl[LNK_EN_BIT];
  assign wr_next    = desc_ctrl[LNK_ID_W-1:0];
  assign clr_en     = start_ok || handoff;
  assign clr_ch     = start_ok ? start_id[ID_W-1:0] : act_q;
  assign busy       = busy_q;
  assign act_id     = act_q;
  assign pend_vec   = pend_q;
  assign sb_done    = done_q;
  assign sb_done_id = did_q;
  assign cfg_err    = err_q;
endmodule

// File: rtl/chain_link_seq.sv
module chain_link_seq
  import chain_link_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     fast_cfg,
  input  logic                  start_valid,
  input  logic [LNK_ID_W-1:0]   start_id,
  input  logic                  desc_valid,
  input  logic [1:0]            desc_type,
  input  logic [LNK_CTRL_W-1:0] desc_ctrl,
  input  logic                  blk_done,
  input  logic                  blk_final,
  output logic [NUM_CH-1:0]     act_vec,
  output logic [NUM_CH-1:0]     pend_vec,
  output logic                  busy,
  output logic                  sb_done,
  output logic [ID_W-1:0]       sb_done_id,
  output logic                  cfg_err
);
  logic                       rst_n_sync;
  logic                       wr_en, wr_arm, clr_en;
  logic [ID_W-1:0]            wr_ch, clr_ch, act_id;
  logic [LNK_ID_W-1:0]        wr_next;
  logic [NUM_CH-1:0]          arm_vec;
  logic [NUM_CH*LNK_ID_W-1:0] next_flat;

  cls_rst_sync rst_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_sync)
  );

  cls_link_bank #(.NUM_CH(NUM_CH)) bank_i (
    .clk(clk), .rst_n(rst_n_sync),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_arm(wr_arm), .wr_next(wr_next),
    .clr_en(clr_en), .clr_ch(clr_ch),
    .arm_vec(arm_vec), .next_flat(next_flat)
  );

  cls_link_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rst_n(rst_n_sync), .fast_cfg(fast_cfg),
    .start_valid(start_valid), .start_id(start_id),
    .desc_valid(desc_valid), .desc_type(desc_type), .desc_ctrl(desc_ctrl),
    .blk_done(blk_done), .blk_final(blk_final),
    .arm_vec(arm_vec), .next_flat(next_flat),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_arm(wr_arm), .wr_next(wr_next),
    .clr_en(clr_en), .clr_ch(clr_ch),
    .busy(busy), .act_id(act_id), .pend_vec(pend_vec),
    .sb_done(sb_done), .sb_done_id(sb_done_id), .cfg_err(cfg_err)
  );

  always_comb begin
    act_vec = '0;
    if (busy) act_vec[act_id] = 1'b1;
  end
endmodule

// File: rtl/chain_link_chk.sv
module chain_link_chk #(
  parameter int NUM_CH = 32,
  localparam int ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic [4:0]        start_id,
  input logic [NUM_CH-1:0] act_vec,
  input logic [NUM_CH-1:0] pend_vec,
  input logic              busy,
  input logic              sb_done,
  input logic              cfg_err
);
  assert_one_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_vec));

  assert_active_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vec & ~pend_vec) == '0);

  assert_busy_matches_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (act_vec != '0));

  assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_valid && (int'(start_id) < NUM_CH))
      |=> (busy && act_vec[$past(start_id[ID_W-1:0])] && !cfg_err));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sb_done |-> (!busy && !cfg_err));

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !busy);
endmodule

bind chain_link_seq chain_link_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n_sync), .start_valid(start_valid), .start_id(start_id),
  .act_vec(act_vec), .pend_vec(pend_vec), .busy(busy),
  .sb_done(sb_done), .cfg_err(cfg_err)
);

// File: tb/chain_link_seq_tb_top.sv
module chain_link_seq_tb_top;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] fast_cfg = 8'b1010_0000;
  logic           start_valid = 1'b0;
  logic [4:0]     start_id = '0;
  logic           desc_valid = 1'b0;
  logic [1:0]     desc_type = '0;
  logic [15:0]    desc_ctrl = '0;
  logic           blk_done = 1'b0;
  logic           blk_final = 1'b0;
  logic [NCH-1:0] act_vec, pend_vec;
  logic           busy, sb_done, cfg_err;
  logic [2:0]     sb_done_id;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chain_link_seq #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fast_cfg(fast_cfg),
    .start_valid(start_valid), .start_id(start_id),
    .desc_valid(desc_valid), .desc_type(desc_type), .desc_ctrl(desc_ctrl),
    .blk_done(blk_done), .blk_final(blk_final),
    .act_vec(act_vec), .pend_vec(pend_vec), .busy(busy),
    .sb_done(sb_done), .sb_done_id(sb_done_id), .cfg_err(cfg_err)
  );

  // behavioural reference model
  int m_busy, m_act, m_err, m_done, m_done_id;
  int m_pend[NCH];
  int m_arm[NCH];
  int m_nxt[NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_act = 0; m_err = 0; m_done = 0; m_done_id = 0;
      for (int i = 0; i < NCH; i++) begin m_pend[i] = 0; m_arm[i] = 0; m_nxt[i] = 0; end
    end else begin
      m_done = 0;
      if (m_busy == 0 && start_valid && start_id < NCH) begin
        m_busy = 1; m_act = start_id; m_pend[start_id] = 1; m_err = 0; m_arm[start_id] = 0;
      end else if (m_busy != 0 && blk_done) begin
        if (blk_final) m_pend[m_act] = 0;
        if (m_arm[m_act] != 0) begin
          int t;
          m_arm[m_act] = 0;
          t = m_nxt[m_act];
          if (t < NCH && !fast_cfg[t]) begin m_act = t; m_pend[t] = 1; end
          else begin m_err = 1; m_busy = 0; end
        end else if (blk_final) begin
          m_done = 1; m_done_id = m_act; m_busy = 0;
        end
      end else if (m_busy != 0 && desc_valid && desc_type == 2'd1) begin
        m_arm[m_act] = desc_ctrl[15];
        m_nxt[m_act] = desc_ctrl[4:0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [NCH-1:0] ea, ep;
      ea = '0; ep = '0;
      for (int i = 0; i < NCH; i++) ep[i] = (m_pend[i] != 0);
      if (m_busy != 0) ea[m_act] = 1'b1;
      chk(act_vec == ea, "R2/R4/R5 model active", int'(act_vec), int'(ea));
      chk(pend_vec == ep, "R10 model pending", int'(pend_vec), int'(ep));
      chk(busy == (m_busy != 0), "R7 model busy", int'(busy), m_busy);
      chk(sb_done == (m_done != 0), "R7 model done", int'(sb_done), m_done);
      if (m_done != 0) chk(int'(sb_done_id) == m_done_id, "R7 model done id", int'(sb_done_id), m_done_id);
      chk(cfg_err == (m_err != 0), "R8 model err", int'(cfg_err), m_err);
      chk($onehot0(act_vec), "R11 one active", int'(act_vec), 0);
    end
  end

  task automatic do_start(input int id);
    @(negedge clk); start_valid = 1'b1; start_id = 5'(id);
    @(negedge clk); start_valid = 1'b0;
  endtask

  task automatic do_desc(input int typ, input bit en, input int nxt);
    @(negedge clk);
    desc_valid = 1'b1; desc_type = 2'(typ);
    desc_ctrl = '0; desc_ctrl[15] = en; desc_ctrl[4:0] = 5'(nxt);
    @(negedge clk); desc_valid = 1'b0;
  endtask

  task automatic do_blk(input bit fin);
    @(negedge clk); blk_done = 1'b1; blk_final = fin;
    @(negedge clk); blk_done = 1'b0; blk_final = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(act_vec == '0 && pend_vec == '0, "R1 reset vectors", int'(act_vec | pend_vec), 0);
    chk(!busy && !cfg_err && !sb_done, "R1 reset flags", int'({busy, cfg_err, sb_done}), 0);

    // chain A: 0 -> 3 (mid) -> 3 self -> 2 (final) -> back to 0
    do_start(9);
    chk(!busy, "R2 out-of-range start ignored", int'(busy), 0);
    do_start(0);
    chk(act_vec == 8'h01, "R2 start ch0", int'(act_vec), 1);
    do_blk(0);
    do_desc(2, 1, 3);
    do_desc(3, 1, 3);
    do_blk(0);
    chk(act_vec == 8'h01, "R3 type2/3 no link", int'(act_vec), 1);
    do_desc(1, 1, 3);
    do_blk(0);
    chk(act_vec == 8'h08 && pend_vec == 8'h09, "R5 mid handoff", int'(pend_vec), 9);
    do_start(4);
    chk(act_vec == 8'h08, "R2 start while busy ignored", int'(act_vec), 8);
    do_desc(1, 1, 3);
    do_blk(0);
    chk(act_vec == 8'h08, "R6 self link", int'(act_vec), 8);
    do_blk(0);
    chk(act_vec == 8'h08 && busy, "R6 arm consumed", int'(act_vec), 8);
    do_desc(1, 1, 2);
    do_blk(1);
    chk(act_vec == 8'h04 && pend_vec == 8'h05, "R4 final handoff", int'(pend_vec), 5);
    do_desc(1, 1, 0);
    do_blk(1);
    chk(act_vec == 8'h01 && pend_vec == 8'h01, "R10 resume pending", int'(pend_vec), 1);
    @(negedge clk); blk_done = 1'b1; blk_final = 1'b1;
    @(negedge clk); blk_done = 1'b0; blk_final = 1'b0;
    chk(sb_done && sb_done_id == 3'd0, "R7 done pulse", int'(sb_done_id), 0);
    chk(pend_vec == '0 && !busy, "R10 final clears pending", int'(pend_vec), 0);
    @(negedge clk);
    chk(!sb_done, "R7 done one cycle", int'(sb_done), 0);

    // chain B: fast head 5 links into fast 7
    do_start(5);
    chk(act_vec == 8'h20, "R2 fast head accepted", int'(act_vec), 32);
    do_desc(1, 1, 7);
    do_blk(1);
    chk(cfg_err && !busy && act_vec == '0, "R8 link into fast", int'(cfg_err), 1);
    do_start(1);
    chk(!cfg_err && act_vec == 8'h02, "R8 err cleared by start", int'(cfg_err), 0);
    do_blk(1);

    // chain C: fast self link
    do_start(7);
    do_desc(1, 1, 7);
    do_blk(0);
    chk(cfg_err && act_vec == '0, "R8 fast self link", int'(cfg_err), 1);
    chk(pend_vec[7], "R8 mid block leaves pending", int'(pend_vec), 128);

    // chain D: out-of-range next id
    do_start(1);
    do_desc(1, 1, 12);
    do_blk(1);
    chk(cfg_err && !busy, "R9 out-of-range next", int'(cfg_err), 1);

    // chain E: disarmed link is not taken
    do_start(2);
    do_desc(1, 1, 4);
    do_desc(1, 0, 4);
    do_blk(1);
    chk(sb_done && sb_done_id == 3'd2, "R3 disarm then done", int'(sb_done_id), 2);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule